// File: doc/BRIEF.md
# Parallel Port Microsequencer Engine

This block is a small instruction-driven controller that executes short programs of port-access microinstructions held in an external instruction memory. Each instruction has a 5-bit opcode and up to three 16-bit arguments. The engine reads, writes and read-modify-writes the registers of a parallel-port register block. It branches on the bits of that block's status register. It can also stall on a microsecond tick, stream bytes between a buffer memory and a port register, and call one subsequence.

The engine keeps a program counter, a signed 16-bit branch counter, a buffer pointer and one saved return address. Software pulses `start` while the engine is idle. The engine then runs from address 0 until a finishing instruction executes. At that point it latches the instruction's code onto `ret_code` and holds `done` high until the next start. Instruction memory, buffer memory and the register block all answer combinationally within the same cycle.

Top module: `port_microseq`

## Requirements
- R1: After reset, `busy`, `done` and `ret_code` are all 0.
- R2: Opcode 2 reads the register selected by arg0[1:0] and ANDs it with arg1[7:0]. It writes the result to the buffer address arg2[7:0]. It takes one cycle.
- R3: Opcode 3 writes back the selected register (arg0[1:0]) with the bits of arg1[7:0] set and the bits of arg2[7:0] cleared, in one read-modify-write cycle. Clearing wins where the two masks overlap, and all other bits are kept.
- R4: Opcode 4 writes arg1[7:0] to the register selected by arg0[1:0] in one cycle. No register or buffer write ever happens while the engine is idle.
- R5: Opcode 5 with a nonzero arg0 stalls the program until arg0 microsecond ticks have been counted, and takes arg0+2 cycles when the tick is high every cycle. With arg0 = 0 it takes one cycle. While the tick stays low the program does not advance.
- R6: Opcode 6 loads arg0 into the branch counter. Opcode 7 decrements the counter and branches by the signed arg0 only when the new value is greater than zero. Every branch target is the index of the following instruction plus the signed offset, modulo the program size. Start clears the counter and the pointer.
- R7: Opcode 8 branches by arg1 when any status bit (register 1) selected by the mask arg0[7:0] is 1. Opcode 9 branches by arg1 when any selected status bit is 0.
- R8: Opcode 14 branches by arg2 only when every status bit in arg0[7:0] is 1 and every status bit in arg1[7:0] is 0.
- R9: Opcode 10, outside a subsequence, ends the program. It latches arg0 to `ret_code`, drops `busy` and raises `done` one cycle after it executes. `done` stays high and `ret_code` stays stable until the next start. Each instruction other than a delay or a stream takes one cycle.
- R10: Opcode 16 jumps to arg0[5:0] and saves the following index. Opcode 15 inside the subsequence resumes at the saved index.
- R11: Opcode 12 loads the pointer from arg0[7:0]. Opcode 17 writes arg0 successive buffer bytes, starting at the pointer, to the register selected by arg1[1:0]. Opcode 18 reads that register arg0 times and stores each value ANDed with arg2[7:0] at successive pointer addresses. Both advance the pointer once per byte and take arg0+1 cycles, or one cycle when arg0 = 0.
- R12: A call inside a subsequence, a subsequence return outside one, a finishing opcode inside one, and any other opcode value all end the program with code 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted while idle |
| busy | output | 1 | Program running |
| done | output | 1 | Program finished, held until next start |
| ret_code | output | 16 | Code of the finishing instruction |
| imem_addr | output | 6 | Instruction index (program counter) |
| imem_op | input | 5 | Opcode at `imem_addr` |
| imem_arg0 | input | 16 | First argument |
| imem_arg1 | input | 16 | Second argument |
| imem_arg2 | input | 16 | Third argument |
| buf_addr | output | 8 | Buffer memory address |
| buf_we | output | 1 | Buffer write enable |
| buf_wdata | output | 8 | Buffer write data |
| buf_rdata | input | 8 | Buffer read data at `buf_addr` |
| reg_sel | output | 2 | Port register select |
| reg_we | output | 1 | Port register write enable |
| reg_wdata | output | 8 | Port register write data |
| reg_rdata | input | 8 | Selected port register value |
| us_tick | input | 1 | One-cycle microsecond tick |

## Verification
The same branch program runs under two status values. Each branch form is then seen both taken and not taken, which shows whether the any-set, any-clear and all-match tests are distinct. Counted loops start from 3 and from 0, which shows the difference between a branch on the decremented value and one on the old value. Stream transfers of lengths 4, 0 and 3 separate per-byte pointer advance from a single step. Delays of 0, 1 and 5 ticks, plus a run with the tick held low, fix the stall length exactly. Each error program hits one abort cause on its own: nested call, stray subsequence return, finish inside a subsequence, or an undefined opcode.

// File: rtl/pmseq_pkg.sv
package pmseq_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_REG_READ   = 5'd2,
    OP_REG_MOD    = 5'd3,
    OP_REG_WRITE  = 5'd4,
    OP_WAIT_US    = 5'd5,
    OP_CNT_LOAD   = 5'd6,
    OP_CNT_LOOP   = 5'd7,
    OP_IF_ANY1    = 5'd8,
    OP_IF_ANY0    = 5'd9,
    OP_FINISH     = 5'd10,
    OP_PTR_LOAD   = 5'd12,
    OP_IF_MATCH   = 5'd14,
    OP_SUB_EXIT   = 5'd15,
    OP_SUB_ENTER  = 5'd16,
    OP_STREAM_OUT = 5'd17,
    OP_STREAM_IN  = 5'd18
  } op_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RUN,
    S_WAIT,
    S_BURST
  } state_e;
endpackage

// File: rtl/pmseq_rstsync.sv
module pmseq_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/pmseq_cond.sv
module pmseq_cond
  import pmseq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] status,
  input  logic [DATA_W-1:0] mask_a,
  input  logic [DATA_W-1:0] mask_b,
  output logic              take
);
  always_comb begin
    case (op)
      OP_IF_ANY1:  take = |(status & mask_a);
      OP_IF_ANY0:  take = |(~status & mask_a);
      OP_IF_MATCH: take = ((status & mask_a) == mask_a) && ((status & mask_b) == '0);
      default:     take = 1'b0;
    endcase
  end
endmodule

// File: rtl/pmseq_usdelay.sv
module pmseq_usdelay #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                     cnt_d = load_val;
    else if (tick && cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/port_microseq.sv
module port_microseq
  import pmseq_pkg::*;
#(
  parameter int PC_W   = 6,
  parameter int ARG_W  = 16,
  parameter int DATA_W = 8,
  parameter int BUF_AW = 8,
  parameter int REG_AW = 2,
  parameter logic [REG_AW-1:0] STAT_SEL = 2'd1,
  parameter logic [ARG_W-1:0]  ERR_CODE = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [ARG_W-1:0]  ret_code,
  output logic [PC_W-1:0]   imem_addr,
  input  logic [OP_W-1:0]   imem_op,
  input  logic [ARG_W-1:0]  imem_arg0,
  input  logic [ARG_W-1:0]  imem_arg1,
  input  logic [ARG_W-1:0]  imem_arg2,
  output logic [BUF_AW-1:0] buf_addr,
  output logic              buf_we,
  output logic [DATA_W-1:0] buf_wdata,
  input  logic [DATA_W-1:0] buf_rdata,
  output logic [REG_AW-1:0] reg_sel,
  output logic              reg_we,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic              us_tick
);
  logic rst_ns;

  state_e                   state_q, state_d;
  logic [PC_W-1:0]          pc_q, pc_d, ret_pc_q, ret_pc_d;
  logic signed [ARG_W-1:0]  br_q, br_d, br_dec;
  logic [BUF_AW-1:0]        ptr_q, ptr_d;
  logic [ARG_W-1:0]         cnt_q, cnt_d, code_q, code_d, fin_code, off_sel;
  logic                     sub_q, sub_d, done_q, done_d, fin;
  logic [PC_W-1:0]          pc_nx, pc_br;
  logic                     dly_load, dly_expired, br_take;
  op_e                      op;

  assign op = op_e'(imem_op);

  pmseq_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ns(rst_ns)
  );

  pmseq_cond #(.DATA_W(DATA_W)) u_cond (
    .op(op), .status(reg_rdata),
    .mask_a(imem_arg0[DATA_W-1:0]), .mask_b(imem_arg1[DATA_W-1:0]),
    .take(br_take)
  );

  pmseq_usdelay #(.CNT_W(ARG_W)) u_dly (
    .clk(clk), .rst_n(rst_ns), .load(dly_load), .load_val(imem_arg0),
    .tick(us_tick), .expired(dly_expired)
  );

  assign pc_nx  = pc_q + PC_W'(1);
  assign pc_br  = pc_nx + off_sel[PC_W-1:0];
  assign br_dec = br_q - ARG_W'(1);

  // offset argument differs by branch form
  always_comb begin
    case (op)
      OP_CNT_LOOP: off_sel = imem_arg0;
      OP_IF_MATCH: off_sel = imem_arg2;
      default:     off_sel = imem_arg1;
    endcase
  end

  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    ret_pc_d  = ret_pc_q;
    br_d      = br_q;
    ptr_d     = ptr_q;
    cnt_d     = cnt_q;
    sub_d     = sub_q;
    done_d    = done_q;
    code_d    = code_q;
    fin       = 1'b0;
    fin_code  = ERR_CODE;
    dly_load  = 1'b0;
    reg_sel   = imem_arg0[REG_AW-1:0];
    reg_we    = 1'b0;
    reg_wdata = imem_arg1[DATA_W-1:0];
    buf_addr  = imem_arg2[BUF_AW-1:0];
    buf_we    = 1'b0;
    buf_wdata = reg_rdata & imem_arg1[DATA_W-1:0];

    case (state_q)
      S_IDLE: begin
        if (start) begin
          state_d = S_RUN;
          pc_d    = '0;
          sub_d   = 1'b0;
          br_d    = '0;
          ptr_d   = '0;
          done_d  = 1'b0;
        end
      end
      S_RUN: begin
        pc_d = pc_nx;
        case (op)
          OP_REG_READ:  buf_we = 1'b1;
          OP_REG_MOD: begin
            reg_we    = 1'b1;
            reg_wdata = (reg_rdata | imem_arg1[DATA_W-1:0]) & ~imem_arg2[DATA_W-1:0];
          end
          OP_REG_WRITE: reg_we = 1'b1;
          OP_WAIT_US: begin
            if (imem_arg0 != '0) begin
              pc_d     = pc_q;
              dly_load = 1'b1;
              state_d  = S_WAIT;
            end
          end
          OP_CNT_LOAD:  br_d = $signed(imem_arg0);
          OP_CNT_LOOP: begin
            br_d = br_dec;
            if (!br_dec[ARG_W-1] && br_dec != '0) pc_d = pc_br;
          end
          OP_IF_ANY1, OP_IF_ANY0, OP_IF_MATCH: begin
            reg_sel = STAT_SEL;
            if (br_take) pc_d = pc_br;
          end
          OP_FINISH: begin
            fin = 1'b1;
            if (!sub_q) fin_code = imem_arg0;
          end
          OP_PTR_LOAD:  ptr_d = imem_arg0[BUF_AW-1:0];
          OP_SUB_EXIT: begin
            if (sub_q) begin
              pc_d  = ret_pc_q;
              sub_d = 1'b0;
            end else begin
              fin = 1'b1;
            end
          end
          OP_SUB_ENTER: begin
            if (sub_q) begin
              fin = 1'b1;
            end else begin
              ret_pc_d = pc_nx;
              pc_d     = imem_arg0[PC_W-1:0];
              sub_d    = 1'b1;
            end
          end
          OP_STREAM_OUT, OP_STREAM_IN: begin
            if (imem_arg0 != '0) begin
              pc_d    = pc_q;
              cnt_d   = imem_arg0;
              state_d = S_BURST;
            end
          end
          default: fin = 1'b1;
        endcase
      end
      S_WAIT: begin
        if (dly_expired) begin
          pc_d    = pc_nx;
          state_d = S_RUN;
        end
      end
      default: begin
        reg_sel  = imem_arg1[REG_AW-1:0];
        buf_addr = ptr_q;
        if (op == OP_STREAM_OUT) begin
          reg_we    = 1'b1;
          reg_wdata = buf_rdata;
        end else begin
          buf_we    = 1'b1;
          buf_wdata = reg_rdata & imem_arg2[DATA_W-1:0];
        end
        ptr_d = ptr_q + BUF_AW'(1);
        cnt_d = cnt_q - ARG_W'(1);
        if (cnt_q == ARG_W'(1)) begin
          pc_d    = pc_nx;
          state_d = S_RUN;
        end
      end
    endcase

    if (fin) begin
      state_d = S_IDLE;
      done_d  = 1'b1;
      code_d  = fin_code;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q  <= S_IDLE;
      pc_q     <= '0;
      ret_pc_q <= '0;
      br_q     <= '0;
      ptr_q    <= '0;
      cnt_q    <= '0;
      sub_q    <= 1'b0;
      done_q   <= 1'b0;
      code_q   <= '0;
    end else begin
      state_q  <= state_d;
      pc_q     <= pc_d;
      ret_pc_q <= ret_pc_d;
      br_q     <= br_d;
      ptr_q    <= ptr_d;
      cnt_q    <= cnt_d;
      sub_q    <= sub_d;
      done_q   <= done_d;
      code_q   <= code_d;
    end
  end

  assign busy      = (state_q != S_IDLE);
  assign done      = done_q;
  assign ret_code  = code_q;
  assign imem_addr = pc_q;
endmodule

// File: rtl/pmseq_chk.sv
module pmseq_chk #(
  parameter int ARG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [ARG_W-1:0] ret_code,
  input logic             reg_we,
  input logic             buf_we
);
  // R9: done only while idle
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9: an accepted start begins a run and clears done
  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));

  // R9: done rises exactly when the run ends
  p_done_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));

  // R9: code holds while idle with no start
  p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(ret_code));

  // R4: no writes while idle
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(reg_we || buf_we));
endmodule

bind port_microseq pmseq_chk #(.ARG_W(ARG_W)) u_chk (
  .clk(clk), .rst_n(rst_ns), .start(start), .busy(busy), .done(done),
  .ret_code(ret_code), .reg_we(reg_we), .buf_we(buf_we)
);

// File: tb/port_microseq_tb.sv
`timescale 1ns/1ps
module port_microseq_tb;
  import pmseq_pkg::*;

  logic        clk, rst_n, start, us_tick;
  logic        busy, done;
  logic [15:0] ret_code;
  logic [5:0]  imem_addr;
  logic [4:0]  imem_op;
  logic [15:0] imem_arg0, imem_arg1, imem_arg2;
  logic [7:0]  buf_addr, buf_wdata, buf_rdata;
  logic        buf_we, reg_we;
  logic [1:0]  reg_sel;
  logic [7:0]  reg_wdata, reg_rdata;

  logic [4:0]  im_op [64];
  logic [15:0] im_a0 [64];
  logic [15:0] im_a1 [64];
  logic [15:0] im_a2 [64];
  logic [7:0]  dut_buf [256];
  logic [7:0]  mbuf [256];
  logic [7:0]  dut_reg [4];
  logic [7:0]  mreg [4];
  int          wr_log[$];
  int          exp_log[$];
  int          checks = 0;
  int          errors = 0;

  port_microseq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .ret_code(ret_code), .imem_addr(imem_addr), .imem_op(imem_op),
    .imem_arg0(imem_arg0), .imem_arg1(imem_arg1), .imem_arg2(imem_arg2),
    .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .us_tick(us_tick)
  );

  assign imem_op   = im_op[imem_addr];
  assign imem_arg0 = im_a0[imem_addr];
  assign imem_arg1 = im_a1[imem_addr];
  assign imem_arg2 = im_a2[imem_addr];
  assign buf_rdata = dut_buf[buf_addr];
  assign reg_rdata = dut_reg[reg_sel];

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (buf_we) dut_buf[buf_addr] <= buf_wdata;
    if (reg_we) begin
      dut_reg[reg_sel] <= reg_wdata;
      wr_log.push_back(int'({reg_sel, reg_wdata}));
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) begin
      im_op[i] = 5'd0; im_a0[i] = '0; im_a1[i] = '0; im_a2[i] = '0;
    end
  endtask

  task automatic ins(input int idx, input logic [4:0] op,
                     input logic [15:0] x, input logic [15:0] y, input logic [15:0] z);
    im_op[idx] = op; im_a0[idx] = x; im_a1[idx] = y; im_a2[idx] = z;
  endtask

  task automatic set_reg(input int idx, input logic [7:0] v);
    dut_reg[idx] = v; mreg[idx] = v;
  endtask

  task automatic set_buf(input int a, input logic [7:0] v);
    dut_buf[a] = v; mbuf[a] = v;
  endtask

  // Behavioural reference: interprets the program from the requirements.
  // The tick is held high during modelled runs.
  task automatic model(output int cyc, output logic [15:0] code);
    int pc = 0, rpc = 0, ptr = 0, steps = 0;
    bit sub = 0, fin = 0;
    logic signed [15:0] br = 0;
    cyc = 0; code = 0;
    while (!fin && steps < 2000) begin
      logic [4:0]  op = im_op[pc];
      logic [15:0] x = im_a0[pc], y = im_a1[pc], z = im_a2[pc];
      logic [7:0]  st = mreg[1];
      int nx = (pc + 1) & 63;
      bit tk = 0;
      steps++;
      case (op)
        5'd2: begin mbuf[z[7:0]] = mreg[x[1:0]] & y[7:0]; cyc++; pc = nx; end
        5'd3: begin
          mreg[x[1:0]] = (mreg[x[1:0]] | y[7:0]) & ~z[7:0];
          exp_log.push_back(int'({x[1:0], mreg[x[1:0]]})); cyc++; pc = nx;
        end
        5'd4: begin
          mreg[x[1:0]] = y[7:0];
          exp_log.push_back(int'({x[1:0], y[7:0]})); cyc++; pc = nx;
        end
        5'd5: begin cyc += (x == 0) ? 1 : int'(x) + 2; pc = nx; end
        5'd6: begin br = $signed(x); cyc++; pc = nx; end
        5'd7: begin
          br = br - 16'sd1; cyc++;
          pc = (br > 0) ? ((nx + int'($signed(x))) & 63) : nx;
        end
        5'd8, 5'd9, 5'd14: begin
          if (op == 5'd8)      tk = (st & x[7:0]) != 0;
          else if (op == 5'd9) tk = (~st & x[7:0]) != 0;
          else                 tk = ((st & x[7:0]) == x[7:0]) && ((st & y[7:0]) == 0);
          cyc++;
          pc = tk ? ((nx + int'($signed(op == 5'd14 ? z : y))) & 63) : nx;
        end
        5'd10: begin fin = 1; cyc++; code = sub ? 16'hFFFF : x; end
        5'd12: begin ptr = x[7:0]; cyc++; pc = nx; end
        5'd15: begin
          cyc++;
          if (sub) begin pc = rpc; sub = 0; end
          else begin fin = 1; code = 16'hFFFF; end
        end
        5'd16: begin
          cyc++;
          if (sub) begin fin = 1; code = 16'hFFFF; end
          else begin rpc = nx; pc = x[5:0]; sub = 1; end
        end
        5'd17, 5'd18: begin
          cyc += (x == 0) ? 1 : int'(x) + 1;
          for (int i = 0; i < int'(x); i++) begin
            if (op == 5'd17) begin
              mreg[y[1:0]] = mbuf[ptr];
              exp_log.push_back(int'({y[1:0], mbuf[ptr]}));
            end else begin
              mbuf[ptr] = mreg[y[1:0]] & z[7:0];
            end
            ptr = (ptr + 1) & 255;
          end
          pc = nx;
        end
        default: begin fin = 1; cyc++; code = 16'hFFFF; end
      endcase
    end
  endtask

  task automatic run_prog(input string req, input string name);
    int ec, mis;
    logic [15:0] ecode;
    bit bad;
    exp_log.delete();
    wr_log.delete();
    model(ec, ecode);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    bad = !(busy === 1'b1 && done === 1'b0);
    for (int k = 1; k <= ec; k++) begin
      @(negedge clk);
      if (done !== (k >= ec) || busy !== (k < ec)) bad = 1;
    end
    chk(!bad, req, {name, " done timing"}, int'(done), 1);
    chk(ret_code === ecode, req, {name, " return code"}, int'(ret_code), int'(ecode));
    mis = 0;
    for (int i = 0; i < 4; i++)   if (dut_reg[i] !== mreg[i]) mis++;
    for (int i = 0; i < 256; i++) if (dut_buf[i] !== mbuf[i]) mis++;
    chk(mis == 0, req, {name, " register/buffer mismatches"}, mis, 0);
    mis = (wr_log.size() != exp_log.size()) ? 1 : 0;
    if (mis == 0)
      for (int i = 0; i < wr_log.size(); i++) if (wr_log[i] != exp_log[i]) mis++;
    chk(mis == 0, req, {name, " register write sequence"}, wr_log.size(), exp_log.size());
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; us_tick = 1'b1;
    for (int i = 0; i < 256; i++) set_buf(i, 8'h00);
    for (int i = 0; i < 4; i++)   set_reg(i, 8'h00);
    clear_prog();
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && ret_code === 16'h0, "R1", "reset outputs",
        int'({busy, done, ret_code}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1", "idle after release", int'({busy, done}), 0);

    // R2 R3 R4: writes, read-modify-write with overlapping masks, masked fetches
    clear_prog();
    ins(0, OP_REG_WRITE, 0, 16'h5A, 0);
    ins(1, OP_REG_WRITE, 2, 16'h0F, 0);
    ins(2, OP_REG_MOD,   2, 16'hC1, 16'h03);
    ins(3, OP_REG_MOD,   0, 16'h81, 16'h01);
    ins(4, OP_REG_READ,  2, 16'hF0, 16'h10);
    ins(5, OP_REG_READ,  0, 16'hFF, 16'h11);
    ins(6, OP_FINISH,    16'h0001, 0, 0);
    run_prog("R2 R3 R4", "register ops");
    chk(dut_reg[0] === 8'hDA, "R3", "clear wins on overlap", int'(dut_reg[0]), 8'hDA);

    // R5: delays 0, 5, 1 with tick high
    clear_prog();
    ins(0, OP_WAIT_US, 0, 0, 0);
    ins(1, OP_WAIT_US, 5, 0, 0);
    ins(2, OP_REG_WRITE, 0, 16'h01, 0);
    ins(3, OP_WAIT_US, 1, 0, 0);
    ins(4, OP_FINISH, 16'h0002, 0, 0);
    run_prog("R5", "delays");

    // R5: tick held low stalls the program
    clear_prog();
    ins(0, OP_WAIT_US, 3, 0, 0);
    ins(1, OP_FINISH, 16'h0033, 0, 0);
    us_tick = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (12) @(negedge clk);
    chk(busy === 1'b1 && done === 1'b0, "R5", "stall without tick", int'({busy, done}), 2);
    us_tick = 1'b1;
    repeat (6) @(negedge clk);
    chk(done === 1'b1 && ret_code === 16'h0033, "R5", "resume after ticks",
        int'(ret_code), 16'h33);

    // R6 R11: counted loop from 3 (three passes), pointer advance
    set_reg(0, 8'h5C);
    clear_prog();
    ins(0, OP_PTR_LOAD, 16'h40, 0, 0);
    ins(1, OP_CNT_LOAD, 3, 0, 0);
    ins(2, OP_STREAM_IN, 1, 0, 16'hFF);
    ins(3, OP_CNT_LOOP, 16'hFFFE, 0, 0);
    ins(4, OP_FINISH, 16'h0004, 0, 0);
    run_prog("R6", "loop from 3");
    chk(dut_buf[8'h42] === 8'h5C && dut_buf[8'h43] === 8'h00, "R6", "three passes",
        int'({dut_buf[8'h42], dut_buf[8'h43]}), 16'h5C00);

    // R6: loop from 0 runs the body once
    set_reg(0, 8'h77);
    ins(1, OP_CNT_LOAD, 0, 0, 0);
    run_prog("R6", "loop from 0");
    chk(dut_buf[8'h40] === 8'h77 && dut_buf[8'h41] === 8'h5C, "R6", "single pass",
        int'({dut_buf[8'h40], dut_buf[8'h41]}), 16'h775C);

    // R7 R8: branch forms under two status patterns
    clear_prog();
    ins(0,  OP_IF_ANY1,  16'h01, 1, 0);
    ins(1,  OP_REG_READ, 3, 16'hFF, 16'h20);
    ins(2,  OP_IF_ANY1,  16'h20, 1, 0);
    ins(3,  OP_REG_READ, 3, 16'hFF, 16'h21);
    ins(4,  OP_IF_ANY0,  16'h21, 1, 0);
    ins(5,  OP_REG_READ, 3, 16'hFF, 16'h22);
    ins(6,  OP_IF_ANY0,  16'hA0, 1, 0);
    ins(7,  OP_REG_READ, 3, 16'hFF, 16'h23);
    ins(8,  OP_IF_MATCH, 16'hA0, 16'h01, 1);
    ins(9,  OP_REG_READ, 3, 16'hFF, 16'h24);
    ins(10, OP_IF_MATCH, 16'hA0, 16'h20, 1);
    ins(11, OP_REG_READ, 3, 16'hFF, 16'h25);
    ins(12, OP_FINISH, 16'h0006, 0, 0);
    set_reg(1, 8'hA0); set_reg(3, 8'hEE);
    for (int i = 8'h20; i <= 8'h25; i++) set_buf(i, 8'h00);
    run_prog("R7 R8", "branches status A0");
    chk(dut_buf[8'h21] === 8'h00 && dut_buf[8'h20] === 8'hEE, "R7", "any-set taken/not",
        int'({dut_buf[8'h20], dut_buf[8'h21]}), 16'hEE00);
    chk(dut_buf[8'h24] === 8'h00 && dut_buf[8'h25] === 8'hEE, "R8", "all-match taken/not",
        int'({dut_buf[8'h24], dut_buf[8'h25]}), 16'h00EE);
    set_reg(1, 8'h5F); set_reg(3, 8'h99);
    for (int i = 8'h20; i <= 8'h25; i++) set_buf(i, 8'h00);
    run_prog("R7 R8", "branches status 5F");

    // R10: call and return
    clear_prog();
    ins(0,  OP_SUB_ENTER, 10, 0, 0);
    ins(1,  OP_REG_WRITE, 0, 16'h33, 0);
    ins(2,  OP_FINISH, 16'h0007, 0, 0);
    ins(10, OP_REG_WRITE, 2, 16'h44, 0);
    ins(11, OP_SUB_EXIT, 0, 0, 0);
    run_prog("R10", "subsequence");

    // R11: streams of length 4, 0, 3
    set_buf(8'h80, 8'h11); set_buf(8'h81, 8'h22); set_buf(8'h82, 8'h33); set_buf(8'h83, 8'h44);
    set_reg(2, 8'hA5);
    clear_prog();
    ins(0, OP_PTR_LOAD, 16'h80, 0, 0);
    ins(1, OP_STREAM_OUT, 4, 0, 0);
    ins(2, OP_STREAM_OUT, 0, 2, 0);
    ins(3, OP_STREAM_IN, 3, 2, 16'h3C);
    ins(4, OP_FINISH, 16'h0009, 0, 0);
    run_prog("R11", "pointer streams");
    chk(dut_buf[8'h86] === 8'h24 && dut_buf[8'h87] === 8'h00, "R11", "fetch stream end",
        int'({dut_buf[8'h86], dut_buf[8'h87]}), 16'h2400);

    // R12: abort causes
    clear_prog();
    ins(0, OP_SUB_ENTER, 10, 0, 0);
    ins(10, OP_SUB_ENTER, 20, 0, 0);
    run_prog("R12", "nested call");
    clear_prog();
    ins(0, OP_SUB_EXIT, 0, 0, 0);
    run_prog("R12", "stray subsequence return");
    clear_prog();
    ins(0, OP_SUB_ENTER, 10, 0, 0);
    ins(10, OP_REG_WRITE, 0, 16'h77, 0);
    ins(11, OP_FINISH, 16'h0005, 0, 0);
    run_prog("R12", "finish inside subsequence");
    clear_prog();
    ins(0, OP_REG_WRITE, 2, 16'h12, 0);
    ins(1, 5'd11, 0, 0, 0);
    run_prog("R12", "undefined opcode 11");
    clear_prog();
    ins(0, 5'd19, 0, 0, 0);
    run_prog("R12", "undefined opcode 19");

    // R9: code and done held while idle
    repeat (5) @(negedge clk);
    chk(done === 1'b1 && ret_code === 16'hFFFF, "R9", "idle hold", int'(ret_code), 16'hFFFF);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule